// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block is a fully associative translation buffer that maps virtual pages to physical pages on behalf of a processor's load and store pipe. Each entry describes an aligned pair of neighbouring virtual pages. The pair shares one tag and one address-space tag, and each of its two pages has its own physical page number and its own flags. A lookup compares every entry in the same cycle. It returns a physical page number, or an exception code that the trap logic uses to choose a handler.

Refill is done by software. It writes an entry either at an index it names or at an index taken from a down-counter that runs on its own. That counter never goes below a programmable floor, so entries under the floor stay resident. The same software side can probe for an entry that matches a page and address space, and can read back every field of any entry. Lookups, probes and reads are combinational. Writes and floor updates take effect at the clock edge.

Top module: `tlb_paired`

## Requirements
- R1: After reset every field of every entry is zero, the wired floor is 0 and `rnd_idx_o` is ENTRIES-1.
- R2: An entry matches when its pair tag equals the lookup VPN with bit 0 dropped. Bit 0 of the VPN picks the page half: 0 selects half 0 and 1 selects half 1, and the physical page number comes from that half.
- R3: The entry must also match on the 8-bit address-space ID, unless the global flag (flag bit 0) of the selected half is set, in which case the address-space ID is ignored.
- R4: `lk_exc_o` is 1 (refill) when no entry matches, and 2 (invalid) when an entry matches but the selected half has its valid flag (flag bit 1) clear.
- R5: A store (`lk_store_i`=1) to a valid half whose dirty flag (flag bit 2) is clear gives `lk_exc_o`=3 (modify). Loads to that half, and stores to a dirty half, translate with code 0.
- R6: `lk_uncached_o` reports the noncacheable flag (flag bit 3) of the selected half of the matching entry.
- R7: `rnd_idx_o` decrements by one every cycle. In the cycle after it equals the wired floor it becomes ENTRIES-1, so it stays in the range from the floor to ENTRIES-1.
- R8: A write of the wired floor takes effect at the clock edge, and it reloads `rnd_idx_o` to ENTRIES-1 in the next cycle.
- R9: A write with `wr_rand_i`=1 stores the entry at the index shown on `rnd_idx_o` in that cycle, which is never below the wired floor.
- R10: When several entries match, the lowest-index match is used and `lk_multi_o` is 1.
- R11: A probe returns the lowest matching index with `pr_miss_o`=0, or `pr_miss_o`=1 with `pr_idx_o`=0 when no entry matches.
- R12: A read returns every field of the entry at `rd_idx_i`. Writes take effect at the clock edge, so a lookup in the same cycle still sees the old contents.
- R13: Whenever `lk_exc_o` is nonzero, `lk_ppn_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_vpn_i | input | 20 | Lookup virtual page number |
| lk_asid_i | input | 8 | Lookup address-space ID |
| lk_store_i | input | 1 | Lookup is a store |
| lk_ppn_o | output | 20 | Translated physical page number |
| lk_exc_o | output | 2 | 0 none, 1 refill, 2 invalid, 3 modify |
| lk_uncached_o | output | 1 | Selected half is noncacheable |
| lk_multi_o | output | 1 | More than one entry matched |
| wr_en_i | input | 1 | Write an entry this cycle |
| wr_rand_i | input | 1 | Use the random index instead of wr_idx_i |
| wr_idx_i | input | log2(ENTRIES) | Explicit write index |
| wr_vpn2_i | input | 19 | Pair tag (VPN without bit 0) |
| wr_asid_i | input | 8 | Entry address-space ID |
| wr_ppn0_i | input | 20 | Half 0 physical page |
| wr_flags0_i | input | 4 | Half 0 flags {nc, dirty, valid, global} |
| wr_ppn1_i | input | 20 | Half 1 physical page |
| wr_flags1_i | input | 4 | Half 1 flags {nc, dirty, valid, global} |
| wired_we_i | input | 1 | Load the wired floor |
| wired_i | input | log2(ENTRIES) | New wired floor |
| rnd_idx_o | output | log2(ENTRIES) | Current replacement index |
| pr_vpn_i | input | 20 | Probe virtual page number |
| pr_asid_i | input | 8 | Probe address-space ID |
| pr_idx_o | output | log2(ENTRIES) | Probe result index |
| pr_miss_o | output | 1 | Probe found no entry |
| rd_idx_i | input | log2(ENTRIES) | Read index |
| rd_vpn2_o | output | 19 | Read pair tag |
| rd_asid_o | output | 8 | Read address-space ID |
| rd_ppn0_o | output | 20 | Read half 0 page |
| rd_flags0_o | output | 4 | Read half 0 flags |
| rd_ppn1_o | output | 20 | Read half 1 page |
| rd_flags1_o | output | 4 | Read half 1 flags |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a lookup hits an entry while software rewrites that entry. The bench provokes this by holding the lookup steady across the write edge, and expects the old page before the edge and the new page after it. In the second, a random-index write coincides with the down-counter wrapping at the wired floor. Each random write is judged by reading back the index that `rnd_idx_o` showed during the write cycle, and by confirming that this index is at or above the floor.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VPN_W  = 20;
  localparam int PPN_W  = 20;
  localparam int ASID_W = 8;
  localparam int FLAG_W = 4;

  typedef struct packed {
    logic [PPN_W-1:0] ppn;
    logic             nc;
    logic             d;
    logic             v;
    logic             g;
  } half_t;

  typedef struct packed {
    logic [VPN_W-2:0]  vpn2;
    logic [ASID_W-1:0] asid;
    half_t [1:0]       half;
  } entry_t;

  typedef enum logic [1:0] {
    EXC_NONE    = 2'd0,
    EXC_REFILL  = 2'd1,
    EXC_INVALID = 2'd2,
    EXC_MODIFY  = 2'd3
  } exc_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64
) (
  input  entry_t [ENTRIES-1:0] ents_i,
  input  logic [VPN_W-1:0]     vpn_i,
  input  logic [ASID_W-1:0]    asid_i,
  output logic [ENTRIES-1:0]   hit_o
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    half_t sel;
    assign sel = ents_i[i].half[vpn_i[0]];
    // global flag of the addressed half waives the ASID compare
    assign hit_o[i] = (ents_i[i].vpn2 == vpn_i[VPN_W-1:1]) &&
                      (sel.g || (ents_i[i].asid == asid_i));
  end
endmodule

// File: rtl/tlb_prio.sv
module tlb_prio #(
  parameter int N = 64,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     hit_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o,
  output logic             multi_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o   = |hit_i;
  assign multi_o = |(hit_i & (hit_i - 1'b1));
endmodule

// File: rtl/tlb_rnd.sv
module tlb_rnd #(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_i,
  input  logic [IDX_W-1:0] floor_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 idx_o <= TOP;
    else if (reload_i)           idx_o <= TOP;
    else if (idx_o <= floor_i)   idx_o <= TOP;
    else                         idx_o <= idx_o - 1'b1;
  end
endmodule

// File: rtl/tlb_paired.sv
module tlb_paired
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic              lk_store_i,
  output logic [PPN_W-1:0]  lk_ppn_o,
  output logic [1:0]        lk_exc_o,
  output logic              lk_uncached_o,
  output logic              lk_multi_o,
  input  logic              wr_en_i,
  input  logic              wr_rand_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [VPN_W-2:0]  wr_vpn2_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic [PPN_W-1:0]  wr_ppn0_i,
  input  logic [FLAG_W-1:0] wr_flags0_i,
  input  logic [PPN_W-1:0]  wr_ppn1_i,
  input  logic [FLAG_W-1:0] wr_flags1_i,
  input  logic              wired_we_i,
  input  logic [IDX_W-1:0]  wired_i,
  output logic [IDX_W-1:0]  rnd_idx_o,
  input  logic [VPN_W-1:0]  pr_vpn_i,
  input  logic [ASID_W-1:0] pr_asid_i,
  output logic [IDX_W-1:0]  pr_idx_o,
  output logic              pr_miss_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [VPN_W-2:0]  rd_vpn2_o,
  output logic [ASID_W-1:0] rd_asid_o,
  output logic [PPN_W-1:0]  rd_ppn0_o,
  output logic [FLAG_W-1:0] rd_flags0_o,
  output logic [PPN_W-1:0]  rd_ppn1_o,
  output logic [FLAG_W-1:0] rd_flags1_o
);
  entry_t [ENTRIES-1:0] ents_q;
  logic [IDX_W-1:0]     wired_q;
  logic [IDX_W-1:0]     wr_sel;

  assign wr_sel = wr_rand_i ? rnd_idx_o : wr_idx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ents_q  <= '0;
      wired_q <= '0;
    end else begin
      if (wr_en_i) begin
        ents_q[wr_sel].vpn2    <= wr_vpn2_i;
        ents_q[wr_sel].asid    <= wr_asid_i;
        ents_q[wr_sel].half[0] <= half_t'({wr_ppn0_i, wr_flags0_i});
        ents_q[wr_sel].half[1] <= half_t'({wr_ppn1_i, wr_flags1_i});
      end
      if (wired_we_i) wired_q <= wired_i;
    end
  end

  tlb_rnd #(.ENTRIES(ENTRIES)) u_rnd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .reload_i (wired_we_i),
    .floor_i  (wired_q),
    .idx_o    (rnd_idx_o)
  );

  // lookup path
  logic [ENTRIES-1:0] lk_hit;
  logic [IDX_W-1:0]   lk_idx;
  logic               lk_any;
  half_t              lk_half;

  tlb_cam #(.ENTRIES(ENTRIES)) u_lk_cam (
    .ents_i (ents_q),
    .vpn_i  (lk_vpn_i),
    .asid_i (lk_asid_i),
    .hit_o  (lk_hit)
  );

  tlb_prio #(.N(ENTRIES)) u_lk_prio (
    .hit_i   (lk_hit),
    .idx_o   (lk_idx),
    .any_o   (lk_any),
    .multi_o (lk_multi_o)
  );

  assign lk_half = ents_q[lk_idx].half[lk_vpn_i[0]];

  always_comb begin
    lk_exc_o      = EXC_NONE;
    lk_ppn_o      = '0;
    lk_uncached_o = 1'b0;
    if (!lk_any)                      lk_exc_o = EXC_REFILL;
    else if (!lk_half.v)              lk_exc_o = EXC_INVALID;
    else if (lk_store_i && !lk_half.d) lk_exc_o = EXC_MODIFY;
    else begin
      lk_ppn_o      = lk_half.ppn;
      lk_uncached_o = lk_half.nc;
    end
  end

  // probe path
  logic [ENTRIES-1:0] pr_hit;
  logic               pr_any;
  logic               pr_multi;

  tlb_cam #(.ENTRIES(ENTRIES)) u_pr_cam (
    .ents_i (ents_q),
    .vpn_i  (pr_vpn_i),
    .asid_i (pr_asid_i),
    .hit_o  (pr_hit)
  );

  tlb_prio #(.N(ENTRIES)) u_pr_prio (
    .hit_i   (pr_hit),
    .idx_o   (pr_idx_o),
    .any_o   (pr_any),
    .multi_o (pr_multi)
  );

  assign pr_miss_o = !pr_any;

  // read path
  entry_t rd_ent;
  assign rd_ent      = ents_q[rd_idx_i];
  assign rd_vpn2_o   = rd_ent.vpn2;
  assign rd_asid_o   = rd_ent.asid;
  assign {rd_ppn0_o, rd_flags0_o} = rd_ent.half[0];
  assign {rd_ppn1_o, rd_flags1_o} = rd_ent.half[1];
endmodule

// File: rtl/tlb_paired_chk.sv
module tlb_paired_chk
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [VPN_W-1:0]  lk_vpn_i,
  input logic [ASID_W-1:0] lk_asid_i,
  input logic              lk_store_i,
  input logic [PPN_W-1:0]  lk_ppn_o,
  input logic [1:0]        lk_exc_o,
  input logic              lk_multi_o,
  input logic [VPN_W-1:0]  pr_vpn_i,
  input logic [ASID_W-1:0] pr_asid_i,
  input logic              pr_miss_o,
  input logic [IDX_W-1:0]  rnd_idx_o,
  input logic [IDX_W-1:0]  wired_q,
  input logic              wired_we_i
);
  // R7
  rnd_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rnd_idx_o >= wired_q && int'(rnd_idx_o) <= ENTRIES - 1);

  // R7
  rnd_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rnd_idx_o > wired_q && !wired_we_i) |=> rnd_idx_o == $past(rnd_idx_o) - 1'b1);

  // R8
  wired_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wired_we_i |=> int'(rnd_idx_o) == ENTRIES - 1);

  // R5
  modify_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_exc_o == EXC_MODIFY |-> lk_store_i);

  // R13
  exc_ppn_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_exc_o != EXC_NONE |-> lk_ppn_o == '0);

  // R11
  probe_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_vpn_i == pr_vpn_i && lk_asid_i == pr_asid_i) |-> pr_miss_o == (lk_exc_o == EXC_REFILL));

  // R10
  multi_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_multi_o |-> lk_exc_o != EXC_REFILL);
endmodule

bind tlb_paired tlb_paired_chk #(.ENTRIES(ENTRIES)) u_chk (.*);

// File: tb/tlb_paired_tb.sv
`timescale 1ns/1ps
module tlb_paired_tb;
  localparam int N = 8;
  localparam int IW = $clog2(N);

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic [19:0] lk_vpn = 0, pr_vpn = 0;
  logic [7:0]  lk_asid = 0, pr_asid = 0, wr_asid = 0;
  logic        lk_store = 0, wr_en = 0, wr_rand = 0, wired_we = 0;
  logic [IW-1:0] wr_idx = 0, wired = 0, rd_idx = 0;
  logic [18:0] wr_vpn2 = 0;
  logic [19:0] wr_ppn0 = 0, wr_ppn1 = 0;
  logic [3:0]  wr_f0 = 0, wr_f1 = 0;
  logic [19:0] lk_ppn, rd_ppn0, rd_ppn1;
  logic [1:0]  lk_exc;
  logic        lk_nc, lk_multi, pr_miss;
  logic [IW-1:0] rnd_idx, pr_idx;
  logic [18:0] rd_vpn2;
  logic [7:0]  rd_asid;
  logic [3:0]  rd_f0, rd_f1;

  tlb_paired #(.ENTRIES(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_vpn_i(lk_vpn), .lk_asid_i(lk_asid), .lk_store_i(lk_store),
    .lk_ppn_o(lk_ppn), .lk_exc_o(lk_exc), .lk_uncached_o(lk_nc), .lk_multi_o(lk_multi),
    .wr_en_i(wr_en), .wr_rand_i(wr_rand), .wr_idx_i(wr_idx), .wr_vpn2_i(wr_vpn2),
    .wr_asid_i(wr_asid), .wr_ppn0_i(wr_ppn0), .wr_flags0_i(wr_f0),
    .wr_ppn1_i(wr_ppn1), .wr_flags1_i(wr_f1),
    .wired_we_i(wired_we), .wired_i(wired), .rnd_idx_o(rnd_idx),
    .pr_vpn_i(pr_vpn), .pr_asid_i(pr_asid), .pr_idx_o(pr_idx), .pr_miss_o(pr_miss),
    .rd_idx_i(rd_idx), .rd_vpn2_o(rd_vpn2), .rd_asid_o(rd_asid),
    .rd_ppn0_o(rd_ppn0), .rd_flags0_o(rd_f0), .rd_ppn1_o(rd_ppn1), .rd_flags1_o(rd_f1)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // replacement index model built from R7/R8
  int exp_rnd = N - 1, exp_wired = 0;
  always @(posedge clk) begin
    if (!rst_n) exp_rnd = N - 1;
    else if (wired_we) begin exp_rnd = N - 1; exp_wired = int'(wired); end
    else if (exp_rnd <= exp_wired) exp_rnd = N - 1;
    else exp_rnd = exp_rnd - 1;
  end

  task automatic wr(input bit rnd, input int idx, input int v2, input int asid,
                    input int p0, input int f0, input int p1, input int f1);
    wr_en = 1; wr_rand = rnd; wr_idx = IW'(idx); wr_vpn2 = 19'(v2); wr_asid = 8'(asid);
    wr_ppn0 = 20'(p0); wr_f0 = 4'(f0); wr_ppn1 = 20'(p1); wr_f1 = 4'(f1);
    @(posedge clk); #1;
    wr_en = 0; wr_rand = 0;
    @(negedge clk);
  endtask

  task automatic lk(input int vpn, input int asid, input bit st);
    lk_vpn = 20'(vpn); lk_asid = 8'(asid); lk_store = st; #1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(int'(rnd_idx) == N - 1, "R1 rnd", int'(rnd_idx), N - 1);
    for (int i = 0; i < N; i++) begin
      rd_idx = IW'(i); #1;
      chk(rd_vpn2 == 0 && rd_asid == 0 && rd_ppn0 == 0 && rd_ppn1 == 0 && rd_f0 == 0 && rd_f1 == 0,
          "R1 cleared", int'(rd_ppn0), 0);
    end
    lk(40, 3, 0);
    chk(lk_exc == 2'd1, "R1 refill after reset", int'(lk_exc), 1);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < N; i++) wr(0, i, 16 + i, 10 + i, 100 + 2*i, 4'b0110, 101 + 2*i, 4'b0110);

    // R2 R12 R11 sweep
    for (int i = 0; i < N; i++) begin
      for (int h = 0; h < 2; h++) begin
        lk((16 + i) * 2 + h, 10 + i, h[0]);
        chk(lk_exc == 0 && int'(lk_ppn) == 100 + 2*i + h, "R2 half select", int'(lk_ppn), 100 + 2*i + h);
        chk(!lk_multi && !lk_nc, "R6 flags clear", int'({lk_multi, lk_nc}), 0);
        lk((16 + i) * 2 + h, 200, 0);
        chk(lk_exc == 2'd1, "R3 asid mismatch", int'(lk_exc), 1);
        pr_vpn = 20'((16 + i) * 2 + h); pr_asid = 8'(10 + i); #1;
        chk(!pr_miss && int'(pr_idx) == i, "R11 probe hit", int'(pr_idx), i);
      end
      rd_idx = IW'(i); #1;
      chk(int'(rd_vpn2) == 16 + i && int'(rd_asid) == 10 + i && int'(rd_ppn0) == 100 + 2*i &&
          int'(rd_ppn1) == 101 + 2*i && rd_f0 == 4'b0110 && rd_f1 == 4'b0110, "R12 readback", int'(rd_ppn1), 101 + 2*i);
    end
    pr_vpn = 20'd2; pr_asid = 8'd10; #1;
    chk(pr_miss && pr_idx == 0, "R11 probe miss", int'(pr_idx), 0);
    lk(2, 10, 0);
    chk(lk_exc == 2'd1 && lk_ppn == 0, "R4 R13 refill", int'(lk_ppn), 0);

    // R3 global on half 0 only
    wr(0, 3, 19, 13, 106, 4'b0111, 107, 4'b0110);
    lk(38, 99, 0);
    chk(lk_exc == 0 && lk_ppn == 106, "R3 global half", int'(lk_ppn), 106);
    lk(39, 99, 0);
    chk(lk_exc == 2'd1, "R3 non-global half", int'(lk_exc), 1);

    // R4 invalid half
    wr(0, 5, 21, 15, 110, 4'b0110, 111, 4'b0100);
    lk(43, 15, 0);
    chk(lk_exc == 2'd2 && lk_ppn == 0, "R4 invalid", int'(lk_exc), 2);
    lk(42, 15, 0);
    chk(lk_exc == 0 && lk_ppn == 110, "R4 valid half", int'(lk_ppn), 110);

    // R5 R6 clean, uncached half 0
    wr(0, 6, 22, 16, 112, 4'b1010, 113, 4'b0110);
    lk(44, 16, 1);
    chk(lk_exc == 2'd3 && lk_ppn == 0, "R5 modify", int'(lk_exc), 3);
    lk(44, 16, 0);
    chk(lk_exc == 0 && lk_ppn == 112 && lk_nc, "R6 uncached load", int'(lk_ppn), 112);
    lk(45, 16, 1);
    chk(lk_exc == 0 && lk_ppn == 113 && !lk_nc, "R5 dirty store", int'(lk_ppn), 113);

    // R10 duplicate of entry 2 at index 7
    wr(0, 7, 18, 12, 300, 4'b0110, 301, 4'b0110);
    lk(36, 12, 0);
    chk(lk_multi && lk_ppn == 104, "R10 lowest index", int'(lk_ppn), 104);
    pr_vpn = 20'd36; pr_asid = 8'd12; #1;
    chk(!pr_miss && pr_idx == 2, "R10 probe lowest", int'(pr_idx), 2);

    // R12 write while lookup hits the same entry
    lk(32, 10, 0);
    wr_en = 1; wr_idx = 0; wr_vpn2 = 19'd16; wr_asid = 8'd10;
    wr_ppn0 = 20'd500; wr_f0 = 4'b0110; wr_ppn1 = 20'd101; wr_f1 = 4'b0110;
    #1;
    chk(lk_ppn == 100, "R12 old before edge", int'(lk_ppn), 100);
    @(posedge clk); #1; wr_en = 0;
    chk(lk_ppn == 500, "R12 new after edge", int'(lk_ppn), 500);
    @(negedge clk);

    // R7 free-running sweep
    for (int c = 0; c < 20; c++) begin
      chk(int'(rnd_idx) == exp_rnd, "R7 sequence", int'(rnd_idx), exp_rnd);
      @(negedge clk);
    end

    // R8 wired floor
    wired = 3'd5; wired_we = 1;
    @(posedge clk); #1; wired_we = 0;
    @(negedge clk);
    chk(int'(rnd_idx) == N - 1, "R8 reload", int'(rnd_idx), N - 1);
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      chk(int'(rnd_idx) == exp_rnd && rnd_idx >= 5, "R8 floor sweep", int'(rnd_idx), exp_rnd);
    end

    // R9 random writes, including at the wrap point
    for (int k = 0; k < 7; k++) begin
      int e;
      e = int'(rnd_idx);
      chk(e == exp_rnd && e >= 5, "R9 index", e, exp_rnd);
      wr(1, 0, 400 + k, 50, 600 + k, 4'b0110, 700 + k, 4'b0110);
      rd_idx = IW'(e); #1;
      chk(int'(rd_vpn2) == 400 + k && int'(rd_ppn0) == 600 + k, "R9 landed", int'(rd_vpn2), 400 + k);
    end
    rd_idx = IW'(4); #1;
    chk(rd_vpn2 == 16 + 4 && rd_ppn0 == 108, "R9 wired kept", int'(rd_vpn2), 20);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule